// File: doc/BRIEF.md
# Command/Indication Channel Register Interface

This block serves the per-frame command/indication field of a time-division serial frame bus. A frame strobe marks each frame; with it come the received field bits, already pulled out of their slot by the framing logic. The block runs two channels.

The primary channel carries a 4-bit code each way. A received code must hold the same new value for a set number of consecutive frames before it is accepted. The number is two by default. Only then is the code latched into a readable register and a change flag raised. The secondary channel carries a 6-bit code each way. It latches any change at once and flags it. It works only when the terminal timing mode is selected. In each direction the code last written by the host is sent again in every frame.

The change flags are sticky and clear on a host status read. Their OR drives a single interrupt line. Serial framing, slot timing, bus arbitration and the host address decoder sit outside this block.

Top module: `cmdind_port`

## Requirements
- R1: After reset, both receive registers and both transmit codes read all ones (primary 4'hF, secondary 6'h3F), both change flags are 0 and irq is 0.
- R2: The primary transmit code is updated on the clock edge that samples pri_tx_wr, to pri_tx_wdata. It stays on pri_tx_bits, unchanged, for every following frame until the next write.
- R3: A new primary receive value is latched into pri_rx_code, and pri_chg_flag is set, on the edge that samples the second consecutive frame strobe carrying that value (CONFIRM_FRAMES = 2).
- R4: Any frame whose primary value differs from the candidate restarts confirmation from that frame. A value present in a single frame, between frames carrying other values, never reaches pri_rx_code or the flag.
- R5: A confirmed primary value equal to the current pri_rx_code leaves the flag untouched.
- R6: With term_mode = 1, a frame whose secondary value differs from sec_rx_code latches that value on the same strobe edge and sets sec_chg_flag.
- R7: With term_mode = 0, sec_tx_bits is all ones and sec_rx_code reads all ones from the next edge on. sec_chg_flag is never set. A secondary transmit write made meanwhile is stored and appears once term_mode returns to 1.
- R8: Each change flag stays set until an edge that samples stat_rd = 1. A set in that same edge wins over the clear. A second change before the read keeps the flag at 1 and updates the data register.
- R9: Received bits are ignored in any cycle where frame_stb is 0. Neither receive register nor any flag changes.
- R10: irq is 1 exactly when at least one change flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| term_mode | input | 1 | 1 enables the secondary channel (terminal timing) |
| frame_stb | input | 1 | One-cycle pulse per frame; receive bits valid with it |
| pri_rx_bits | input | PRI_W | Primary code received in this frame |
| sec_rx_bits | input | SEC_W | Secondary code received in this frame |
| pri_tx_wr | input | 1 | Host write strobe for the primary transmit code |
| pri_tx_wdata | input | PRI_W | Primary transmit code to store |
| sec_tx_wr | input | 1 | Host write strobe for the secondary transmit code |
| sec_tx_wdata | input | SEC_W | Secondary transmit code to store |
| stat_rd | input | 1 | Host status read; clears both flags |
| pri_tx_bits | output | PRI_W | Primary code to insert in every frame |
| sec_tx_bits | output | SEC_W | Secondary code to insert (all ones when disabled) |
| pri_rx_code | output | PRI_W | Last confirmed primary receive code |
| sec_rx_code | output | SEC_W | Last secondary receive code |
| pri_chg_flag | output | 1 | Sticky primary change flag |
| sec_chg_flag | output | 1 | Sticky secondary change flag |
| irq | output | 1 | OR of the change flags |

## Verification
The bench builds the block with its defaults: a 4-bit primary code, a 6-bit secondary code and two-frame confirmation. The short confirmation window brings glitch rejection, restart of the candidate and confirmation of an unchanged value within a few frames each. Each of these is driven by a table walk that also overlaps status reads with new changes. Directed steps then cover reset values, cycles without a strobe, disabling and re-enabling the secondary channel, and a second reset mid-run.

// File: rtl/cmdind_pkg.sv
// Shared constants for the command/indication port.
// Assumes: nothing beyond IEEE 1800-2017.
package cmdind_pkg;
    localparam int PRI_W_DEF   = 4;
    localparam int SEC_W_DEF   = 6;
    localparam int CONFIRM_DEF = 2;
    localparam int NUM_FLAGS   = 2;

    typedef enum int {
        FLAG_PRI = 0,
        FLAG_SEC = 1
    } flag_idx_e;
endpackage

// File: rtl/cmdind_confirm_filter.sv
// Multi-frame confirmation filter for the primary receive code.
// A value is accepted once it has been seen at CONFIRM consecutive
// frame strobes. Any differing frame reloads the candidate and restarts
// counting. accept pulses only when the confirmed value differs from
// the stored code.
// Assumes: CONFIRM >= 2; strobe is a single-cycle pulse per frame.
module cmdind_confirm_filter #(
    parameter int W       = 4,
    parameter int CONFIRM = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe,
    input  logic [W-1:0] rx_in,
    output logic [W-1:0] code_q,
    output logic         accept
);
    localparam int            CW       = $clog2(CONFIRM + 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(CONFIRM);
    localparam logic [CW-1:0] CNT_LAST = CW'(CONFIRM - 1);
    localparam logic [CW-1:0] CNT_ONE  = CW'(1);

    logic [W-1:0]  cand_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nxt;
    logic          same;
    logic          reach;

    // Purpose: next count and confirmation decision for this frame.
    always_comb begin
        same    = (rx_in == cand_q);
        cnt_nxt = !same ? CNT_ONE : ((cnt_q == CNT_FULL) ? cnt_q : cnt_q + CNT_ONE);
        reach   = strobe && same && (cnt_q == CNT_LAST);
        accept  = reach && (cand_q != code_q);
    end

    // Purpose: candidate, counter and accepted code registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_q <= '1;
            cnt_q  <= CNT_FULL;
            code_q <= '1;
        end else if (strobe) begin
            cand_q <= rx_in;
            cnt_q  <= cnt_nxt;
            if (accept) begin
                code_q <= cand_q;
            end
        end
    end

    // R9: without a strobe the accepted code holds.
    assert_pri_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> (code_q == $past(code_q)));

    // R3: a new code enters only from a strobe whose value matches the prior candidate.
    assert_pri_confirm_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q != $past(code_q)) |->
            ($past(strobe) && ($past(rx_in) == code_q) && ($past(cand_q) == code_q)));
endmodule

// File: rtl/cmdind_change_latch.sv
// Immediate change latch for the secondary receive code.
// Latches any differing value at a strobe and reports it. While
// disabled, the register is forced to the all-ones idle code and no
// change is reported.
// Assumes: strobe is a single-cycle pulse per frame.
module cmdind_change_latch #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         strobe,
    input  logic [W-1:0] rx_in,
    output logic [W-1:0] code_q,
    output logic         changed
);
    // Purpose: detect a new secondary value in this frame.
    always_comb begin
        changed = enable && strobe && (rx_in != code_q);
    end

    // Purpose: hold the latest secondary code, idle while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            code_q <= '1;
        end else if (changed) begin
            code_q <= rx_in;
        end
    end

    // R6: an enabled strobe leaves the register equal to that frame's bits.
    assert_sec_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && strobe) |=> (code_q == $past(rx_in)));

    // R9: no strobe, no change while enabled.
    assert_sec_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !strobe) |=> (code_q == $past(code_q)));
endmodule

// File: rtl/cmdind_irq_flags.sv
// Sticky change flags. Each flag sets on its pulse and clears on a
// status read. A set in the same cycle as the read wins.
// Assumes: clr_i is a single-cycle pulse per host read.
module cmdind_irq_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         clr_i,
    output logic [N-1:0] flag_q
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // Purpose: one sticky flag with set-over-clear priority.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q[i] <= 1'b0;
            end else if (set_i[i]) begin
                flag_q[i] <= 1'b1;
            end else if (clr_i) begin
                flag_q[i] <= 1'b0;
            end
        end

        // R8: a set flag survives until a read.
        assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[i] && !clr_i) |=> flag_q[i]);

        // R8: a read with no concurrent set clears the flag.
        assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i && !set_i[i]) |=> !flag_q[i]);

        // R8: a set always lands, even during a read.
        assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> flag_q[i]);
    end
endmodule

// File: rtl/cmdind_port.sv
// Command/indication channel register interface, top level.
// Holds the two transmit codes, filters the primary receive code over
// several frames, latches secondary changes at once, and keeps the
// sticky change flags with their OR on irq.
// Assumes: receive bits are valid with frame_stb; host strobes last one cycle.
module cmdind_port
    import cmdind_pkg::*;
#(
    parameter int PRI_W          = PRI_W_DEF,
    parameter int SEC_W          = SEC_W_DEF,
    parameter int CONFIRM_FRAMES = CONFIRM_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             term_mode,
    input  logic             frame_stb,
    input  logic [PRI_W-1:0] pri_rx_bits,
    input  logic [SEC_W-1:0] sec_rx_bits,
    input  logic             pri_tx_wr,
    input  logic [PRI_W-1:0] pri_tx_wdata,
    input  logic             sec_tx_wr,
    input  logic [SEC_W-1:0] sec_tx_wdata,
    input  logic             stat_rd,
    output logic [PRI_W-1:0] pri_tx_bits,
    output logic [SEC_W-1:0] sec_tx_bits,
    output logic [PRI_W-1:0] pri_rx_code,
    output logic [SEC_W-1:0] sec_rx_code,
    output logic             pri_chg_flag,
    output logic             sec_chg_flag,
    output logic             irq
);
    logic [PRI_W-1:0]     pri_tx_q;
    logic [SEC_W-1:0]     sec_tx_q;
    logic                 pri_accept;
    logic                 sec_changed;
    logic [NUM_FLAGS-1:0] flag_set;
    logic [NUM_FLAGS-1:0] flag_q;

    // Purpose: host-written transmit codes, idle all ones at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pri_tx_q <= '1;
            sec_tx_q <= '1;
        end else begin
            if (pri_tx_wr) pri_tx_q <= pri_tx_wdata;
            if (sec_tx_wr) sec_tx_q <= sec_tx_wdata;
        end
    end

    // Purpose: drive transmit fields; secondary idles when disabled.
    always_comb begin
        pri_tx_bits = pri_tx_q;
        sec_tx_bits = term_mode ? sec_tx_q : '1;
    end

    cmdind_confirm_filter #(
        .W       (PRI_W),
        .CONFIRM (CONFIRM_FRAMES)
    ) u_pri_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (frame_stb),
        .rx_in  (pri_rx_bits),
        .code_q (pri_rx_code),
        .accept (pri_accept)
    );

    cmdind_change_latch #(
        .W (SEC_W)
    ) u_sec_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (term_mode),
        .strobe  (frame_stb),
        .rx_in   (sec_rx_bits),
        .code_q  (sec_rx_code),
        .changed (sec_changed)
    );

    // Purpose: route change pulses to their flag slots.
    always_comb begin
        flag_set           = '0;
        flag_set[FLAG_PRI] = pri_accept;
        flag_set[FLAG_SEC] = sec_changed;
    end

    cmdind_irq_flags #(
        .N (NUM_FLAGS)
    ) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (flag_set),
        .clr_i  (stat_rd),
        .flag_q (flag_q)
    );

    // Purpose: expose flags and their combined interrupt.
    always_comb begin
        pri_chg_flag = flag_q[FLAG_PRI];
        sec_chg_flag = flag_q[FLAG_SEC];
        irq          = |flag_q;
    end

    // R2: a write shows on the primary transmit field from the next cycle.
    assert_pri_tx_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pri_tx_wr |=> (pri_tx_bits == $past(pri_tx_wdata)));

    // R2: without a write the primary transmit field holds.
    assert_pri_tx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pri_tx_wr |=> (pri_tx_bits == $past(pri_tx_bits)));

    // R7: a disabled secondary channel never raises its flag.
    assert_sec_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!term_mode && !sec_chg_flag) |=> !sec_chg_flag);

    // R5: the primary flag rises only together with a new primary code.
    assert_pri_flag_new_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!pri_chg_flag ##1 pri_chg_flag) |-> (pri_rx_code != $past(pri_rx_code)));
endmodule

// File: tb/cmdind_port_bench.sv
// Self-checking bench for cmdind_port: table walk plus directed tests.
module cmdind_port_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PW = 4;
    localparam int SW = 6;

    typedef struct packed {
        logic [PW-1:0] p_in;
        logic [SW-1:0] s_in;
        logic          rd;
        logic [PW-1:0] p_exp;
        logic          pf_exp;
        logic [SW-1:0] s_exp;
        logic          sf_exp;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t TABLE [NVEC] = '{
        '{4'h5, 6'h3F, 1'b0, 4'hF, 1'b0, 6'h3F, 1'b0}, // R3 first sighting
        '{4'h5, 6'h3F, 1'b0, 4'h5, 1'b1, 6'h3F, 1'b0}, // R3 confirmed
        '{4'h5, 6'h2A, 1'b1, 4'h5, 1'b0, 6'h2A, 1'b1}, // R8 set wins over read
        '{4'h9, 6'h2A, 1'b1, 4'h5, 1'b0, 6'h2A, 1'b0}, // R4 glitch, read clears
        '{4'h5, 6'h2A, 1'b0, 4'h5, 1'b0, 6'h2A, 1'b0}, // R4 restart
        '{4'h5, 6'h2A, 1'b0, 4'h5, 1'b0, 6'h2A, 1'b0}, // R5 same value, no flag
        '{4'hC, 6'h15, 1'b0, 4'h5, 1'b0, 6'h15, 1'b1}, // R6 immediate
        '{4'hC, 6'h16, 1'b0, 4'hC, 1'b1, 6'h16, 1'b1}, // R8 second change
        '{4'hC, 6'h16, 1'b1, 4'hC, 1'b0, 6'h16, 1'b0}, // R8 read clears
        '{4'h0, 6'h16, 1'b0, 4'hC, 1'b0, 6'h16, 1'b0}, // R3 one frame only
        '{4'h0, 6'h16, 1'b0, 4'h0, 1'b1, 6'h16, 1'b0}  // R3 confirmed
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          term_mode = 1'b1;
    logic          frame_stb = 1'b0;
    logic [PW-1:0] pri_rx_bits = '1;
    logic [SW-1:0] sec_rx_bits = '1;
    logic          pri_tx_wr = 1'b0;
    logic [PW-1:0] pri_tx_wdata = '0;
    logic          sec_tx_wr = 1'b0;
    logic [SW-1:0] sec_tx_wdata = '0;
    logic          stat_rd = 1'b0;
    logic [PW-1:0] pri_tx_bits;
    logic [SW-1:0] sec_tx_bits;
    logic [PW-1:0] pri_rx_code;
    logic [SW-1:0] sec_rx_code;
    logic          pri_chg_flag;
    logic          sec_chg_flag;
    logic          irq;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    cmdind_port #(.PRI_W(PW), .SEC_W(SW), .CONFIRM_FRAMES(2)) u_cmdind_port (
        .clk(clk), .rst_n(rst_n), .term_mode(term_mode), .frame_stb(frame_stb),
        .pri_rx_bits(pri_rx_bits), .sec_rx_bits(sec_rx_bits),
        .pri_tx_wr(pri_tx_wr), .pri_tx_wdata(pri_tx_wdata),
        .sec_tx_wr(sec_tx_wr), .sec_tx_wdata(sec_tx_wdata), .stat_rd(stat_rd),
        .pri_tx_bits(pri_tx_bits), .sec_tx_bits(sec_tx_bits),
        .pri_rx_code(pri_rx_code), .sec_rx_code(sec_rx_code),
        .pri_chg_flag(pri_chg_flag), .sec_chg_flag(sec_chg_flag), .irq(irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            fails  = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog (all requirements): actual=hung expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One frame: strobe for one cycle, optional status read in the same cycle.
    task automatic run_frame(input logic [PW-1:0] p, input logic [SW-1:0] s, input logic rd);
        @(negedge clk);
        pri_rx_bits = p;
        sec_rx_bits = s;
        frame_stb   = 1'b1;
        stat_rd     = rd;
        @(negedge clk);
        frame_stb   = 1'b0;
        stat_rd     = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic check_reset();
        check("R1 pri_rx_code", int'(pri_rx_code), 'hF);
        check("R1 sec_rx_code", int'(sec_rx_code), 'h3F);
        check("R1 pri_tx_bits", int'(pri_tx_bits), 'hF);
        check("R1 sec_tx_bits", int'(sec_tx_bits), 'h3F);
        check("R1 pri_chg_flag", int'(pri_chg_flag), 0);
        check("R1 sec_chg_flag", int'(sec_chg_flag), 0);
        check("R1 irq", int'(irq), 0);
    endtask

    initial begin
        do_reset();
        check_reset();

        // R2: primary transmit code held over frames
        @(negedge clk);
        pri_tx_wr = 1'b1; pri_tx_wdata = 4'h6;
        sec_tx_wr = 1'b1; sec_tx_wdata = 6'h0A;
        @(negedge clk);
        pri_tx_wr = 1'b0; sec_tx_wr = 1'b0;
        for (int k = 0; k < 3; k++) begin
            run_frame(4'hF, 6'h3F, 1'b0);
            check("R2 pri_tx_bits held", int'(pri_tx_bits), 'h6);
        end
        check("R2 sec_tx_bits written", int'(sec_tx_bits), 'h0A);

        // Table walk: R3 R4 R5 R6 R8 R10
        for (int i = 0; i < NVEC; i++) begin
            run_frame(TABLE[i].p_in, TABLE[i].s_in, TABLE[i].rd);
            check($sformatf("R3/R4/R5 row %0d pri_rx_code", i), int'(pri_rx_code), int'(TABLE[i].p_exp));
            check($sformatf("R8 row %0d pri_chg_flag", i), int'(pri_chg_flag), int'(TABLE[i].pf_exp));
            check($sformatf("R6 row %0d sec_rx_code", i), int'(sec_rx_code), int'(TABLE[i].s_exp));
            check($sformatf("R8 row %0d sec_chg_flag", i), int'(sec_chg_flag), int'(TABLE[i].sf_exp));
            check($sformatf("R10 row %0d irq", i), int'(irq), int'(TABLE[i].pf_exp | TABLE[i].sf_exp));
        end

        // R8: read alone clears the pending primary flag
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
        check("R8 read clears pri flag", int'(pri_chg_flag), 0);
        check("R10 irq low after read", int'(irq), 0);

        // R9: bits change without strobe for several cycles
        @(negedge clk);
        pri_rx_bits = 4'h3; sec_rx_bits = 6'h01;
        repeat (4) @(negedge clk);
        check("R9 pri_rx_code ignores no-strobe", int'(pri_rx_code), 'h0);
        check("R9 sec_rx_code ignores no-strobe", int'(sec_rx_code), 'h16);
        check("R9 no flag without strobe", int'(irq), 0);

        // R7: secondary disabled
        @(negedge clk); term_mode = 1'b0;
        @(negedge clk);
        check("R7 sec_tx_bits idle", int'(sec_tx_bits), 'h3F);
        check("R7 sec_rx_code idle", int'(sec_rx_code), 'h3F);
        run_frame(4'h0, 6'h05, 1'b0);
        check("R7 no sec flag when disabled", int'(sec_chg_flag), 0);
        check("R7 sec_rx_code stays idle", int'(sec_rx_code), 'h3F);
        @(negedge clk); sec_tx_wr = 1'b1; sec_tx_wdata = 6'h2C;
        @(negedge clk); sec_tx_wr = 1'b0;
        check("R7 sec_tx_bits idle after write", int'(sec_tx_bits), 'h3F);
        term_mode = 1'b1;
        @(negedge clk);
        check("R7 stored write sent on enable", int'(sec_tx_bits), 'h2C);
        run_frame(4'h0, 6'h05, 1'b0);
        check("R6 sec latch after enable", int'(sec_rx_code), 'h05);
        check("R6 sec flag after enable", int'(sec_chg_flag), 1);
        check("R10 irq follows sec flag", int'(irq), 1);

        // R1: reset mid-run restores idle state
        do_reset();
        check_reset();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule